// File: doc/BRIEF.md
# Booth-4:2 Carry-Save Segment Multiplier

This block multiplies a wide two's-complement multiplicand by one short signed multiplier digit, one fixed-width slice of the multiplicand at a time. On a start pulse it captures the multiplicand and the digit. It places the multiplicand in a shift register with an extra head slice filled with copies of the multiplicand's sign bit. On each following cycle it feeds the lowest slice into a partial-product generator. The low slice is always read as an unsigned number. The generator recodes the digit with modified radix-4 Booth windows, which gives half as many rows as a plain AND array. A tree built only of 4:2 compressors then reduces those rows to a sum/carry pair.

The redundant pair for each slice leaves the block registered, together with a slice index and a last-slice flag. One stage later, a carry-propagate adder delivers the same value in plain binary. That adder works on slice k while the compressor tree is already working on slice k+1. A caller combines the per-slice results with weights of 2^(k·SEG_W) to obtain the full signed product. Modular reduction and the control of whole field operations belong to other blocks.

Top module: `booth_seg_mul`

## Requirements
- R1: While `rst` is high at a clock edge, `busy`, `seg_valid` and `prod_valid` are low after that edge.
- R2: A `start` sampled while `busy` is low raises `busy` after the same edge. Slice 0 appears on `seg_valid` with `seg_idx` = 0 one cycle later.
- R3: When `seg_valid` is high, `cs_sum + cs_carry` taken modulo 2^(SEG_W+DIG_W) equals the slice value times the digit. The slice value is unsigned. The digit is two's complement.
- R4: Slices 0 to NSEG come out on consecutive cycles. Slice k < NSEG is `mcand[k·SEG_W +: SEG_W]`. Slice NSEG is SEG_W copies of the multiplicand's top bit. `seg_last` is high exactly with slice NSEG, and `busy` falls at that same edge.
- R5: One cycle after each slice, `prod_valid` is high. In that cycle `prod_idx` equals that slice's index and `prod` equals its sum plus carry.
- R6: A `start` sampled while `busy` is high has no effect. The running slices keep the multiplicand and digit captured at the accepted start, even if `mcand` and `digit` change. No new run begins.
- R7: Take each `prod` of one run and sign-extend it from bit SEG_W+DIG_W-1. Weight slice k by 2^(k·SEG_W) and add the results. The sum equals signed `mcand` times signed `digit`, modulo 2^((NSEG+1)·SEG_W).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Capture operands and begin a run when idle |
| mcand | input | SEG_W*NSEG | Two's-complement multiplicand |
| digit | input | DIG_W | Two's-complement multiplier digit |
| busy | output | 1 | A run is in progress |
| seg_valid | output | 1 | Carry-save outputs hold a slice result |
| seg_idx | output | $clog2(NSEG+1) | Index of the slice on the carry-save outputs |
| seg_last | output | 1 | The slice shown is the sign-extension slice |
| cs_sum | output | SEG_W+DIG_W | Redundant result, sum word |
| cs_carry | output | SEG_W+DIG_W | Redundant result, carry word |
| prod_valid | output | 1 | `prod` holds a resolved slice result |
| prod_idx | output | $clog2(NSEG+1) | Index of the slice on `prod` |
| prod | output | SEG_W+DIG_W | Carry-propagated slice result |

## Verification
During a run, the carry-propagate stage resolves slice k in the same cycle that the compressor tree produces slice k+1. Every run therefore puts both on the outputs together. The bench samples `prod` for slice k and the carry-save pair for slice k+1 at the same instant, and judges each against its own arithmetic expectation. A second overlap comes from asserting `start` for the whole of a run while `mcand` and `digit` carry inverted values. The slice stream must then stay bit-exact for the captured operands and must not restart once the run ends. A sweep over every 8-bit slice value against every 8-bit digit covers the Booth window codes and the sign slice in both polarities.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

    // Selection for one radix-4 row: magnitude choice plus inversion.
    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } booth_sel_t;

    // Window {upper, middle, lower} of the digit mapped to 0, +-1, +-2.
    function automatic booth_sel_t booth_recode(input logic [2:0] win);
        booth_sel_t sel;
        sel = '0;
        case (win)
            3'b001, 3'b010: sel.one = 1'b1;
            3'b011:         sel.two = 1'b1;
            3'b100:         begin sel.neg = 1'b1; sel.two = 1'b1; end
            3'b101, 3'b110: begin sel.neg = 1'b1; sel.one = 1'b1; end
            default:        sel = '0;
        endcase
        return sel;
    endfunction

    // Rows fed to the tree: a power of two, at least four.
    function automatic int tree_rows(input int npp);
        int r;
        r = 4;
        while (r < npp + 1) r = r * 2;
        return r;
    endfunction

endpackage

// File: rtl/bsm_booth_rows.sv
module bsm_booth_rows #(
    parameter int SEG_W = 32,
    parameter int DIG_W = 16,
    parameter int P_W   = SEG_W + DIG_W,
    parameter int NROW  = 16
) (
    input  logic [SEG_W-1:0]           seg,
    input  logic [DIG_W-1:0]           dig,
    output logic [NROW-1:0][P_W-1:0]   rows
);
    import bsm_pkg::*;

    localparam int NPP = DIG_W / 2;

    logic [P_W-1:0] mag1;
    logic [P_W-1:0] mag2;
    logic [NPP-1:0] negv;
    logic [P_W-1:0] corr;

    assign mag1 = {{(P_W-SEG_W){1'b0}}, seg};
    assign mag2 = mag1 << 1;

    for (genvar i = 0; i < NPP; i++) begin : g_pp
        logic [2:0]     win;
        booth_sel_t     sel;
        logic [P_W-1:0] pick;
        if (i == 0) begin : g_low
            assign win = {dig[1:0], 1'b0};
        end else begin : g_mid
            assign win = dig[2*i+1 : 2*i-1];
        end
        assign sel     = booth_recode(win);
        assign pick    = sel.two ? mag2 : (sel.one ? mag1 : '0);
        assign negv[i] = sel.neg;
        assign rows[i] = (sel.neg ? ~pick : pick) << (2 * i);
    end

    // Two's-complement completion: +1 at the base of every inverted row.
    always_comb begin
        corr = '0;
        for (int i = 0; i < NPP; i++) corr[2*i] = negv[i];
    end

    assign rows[NPP] = corr;

    for (genvar j = NPP + 1; j < NROW; j++) begin : g_pad
        assign rows[j] = '0;
    end

endmodule

// File: rtl/bsm_csa42.sv
module bsm_csa42 #(
    parameter int W = 48
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  logic [W-1:0] d,
    output logic [W-1:0] s,
    output logic [W-1:0] cy
);
    logic [W-1:0] x;
    logic [W-1:0] m1;
    logic [W-1:0] lat;
    logic [W-1:0] m2;

    // First adder level; its carry moves one bit up as the lateral carry.
    assign x   = a ^ b ^ c;
    assign m1  = (a & b) | (a & c) | (b & c);
    assign lat = {m1[W-2:0], 1'b0};

    // Second adder level absorbs the fourth input and the lateral carry.
    assign s   = x ^ d ^ lat;
    assign m2  = (x & d) | (x & lat) | (d & lat);
    assign cy  = {m2[W-2:0], 1'b0};

endmodule

// File: rtl/booth_seg_mul.sv
module booth_seg_mul #(
    parameter int SEG_W = 32,
    parameter int DIG_W = 16,
    parameter int NSEG  = 4,
    localparam int MC_W  = SEG_W * NSEG,
    localparam int P_W   = SEG_W + DIG_W,
    localparam int IDX_W = $clog2(NSEG + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [MC_W-1:0]  mcand,
    input  logic [DIG_W-1:0] digit,
    output logic             busy,
    output logic             seg_valid,
    output logic [IDX_W-1:0] seg_idx,
    output logic             seg_last,
    output logic [P_W-1:0]   cs_sum,
    output logic [P_W-1:0]   cs_carry,
    output logic             prod_valid,
    output logic [IDX_W-1:0] prod_idx,
    output logic [P_W-1:0]   prod
);
    import bsm_pkg::*;

    localparam int NPP    = DIG_W / 2;
    localparam int NROW   = tree_rows(NPP);
    localparam int LAYERS = $clog2(NROW) - 1;
    localparam int NODES  = 2 * NROW - 2;
    localparam int SR_W   = MC_W + SEG_W;

    run_state_t       state_q;
    logic [SR_W-1:0]  sreg_q;
    logic [DIG_W-1:0] dig_q;
    logic [IDX_W-1:0] cnt_q;
    logic             at_end;

    assign busy   = (state_q == ST_RUN);
    assign at_end = (cnt_q == IDX_W'(NSEG));

    // Operand capture and slice stepping.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            sreg_q  <= '0;
            dig_q   <= '0;
            cnt_q   <= '0;
        end else if (state_q == ST_IDLE) begin
            if (start) begin
                sreg_q  <= {{SEG_W{mcand[MC_W-1]}}, mcand};
                dig_q   <= digit;
                cnt_q   <= '0;
                state_q <= ST_RUN;
            end
        end else begin
            sreg_q <= sreg_q >> SEG_W;
            cnt_q  <= cnt_q + 1'b1;
            if (at_end) state_q <= ST_IDLE;
        end
    end

    // Partial-product rows for the current slice.
    logic [NROW-1:0][P_W-1:0] rows;

    bsm_booth_rows #(
        .SEG_W (SEG_W),
        .DIG_W (DIG_W),
        .P_W   (P_W),
        .NROW  (NROW)
    ) u_rows (
        .seg  (sreg_q[SEG_W-1:0]),
        .dig  (dig_q),
        .rows (rows)
    );

    // Compressor tree: layer l occupies nodes from offset 2*NROW - 2*(NROW>>l).
    logic [P_W-1:0] node [NODES];

    for (genvar r = 0; r < NROW; r++) begin : g_leaf
        assign node[r] = rows[r];
    end

    for (genvar l = 0; l < LAYERS; l++) begin : g_layer
        localparam int OFF_IN  = 2 * NROW - 2 * (NROW >> l);
        localparam int OFF_OUT = 2 * NROW - 2 * (NROW >> (l + 1));
        for (genvar j = 0; j < (NROW >> l) / 4; j++) begin : g_cmp
            bsm_csa42 #(.W(P_W)) u_cmp (
                .a  (node[OFF_IN + 4*j]),
                .b  (node[OFF_IN + 4*j + 1]),
                .c  (node[OFF_IN + 4*j + 2]),
                .d  (node[OFF_IN + 4*j + 3]),
                .s  (node[OFF_OUT + 2*j]),
                .cy (node[OFF_OUT + 2*j + 1])
            );
        end
    end

    // Redundant output stage.
    always_ff @(posedge clk) begin
        if (rst) begin
            seg_valid <= 1'b0;
            seg_idx   <= '0;
            seg_last  <= 1'b0;
            cs_sum    <= '0;
            cs_carry  <= '0;
        end else begin
            seg_valid <= busy;
            seg_idx   <= cnt_q;
            seg_last  <= busy && at_end;
            cs_sum    <= node[NODES-2];
            cs_carry  <= node[NODES-1];
        end
    end

    // Carry-propagate stage, one slice behind the tree.
    always_ff @(posedge clk) begin
        if (rst) begin
            prod_valid <= 1'b0;
            prod_idx   <= '0;
            prod       <= '0;
        end else begin
            prod_valid <= seg_valid;
            prod_idx   <= seg_idx;
            prod       <= cs_sum + cs_carry;
        end
    end

endmodule

// File: rtl/bsm_chk.sv
module bsm_chk #(
    parameter int NSEG  = 4,
    parameter int IDX_W = 3,
    parameter int P_W   = 48
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             seg_valid,
    input logic [IDX_W-1:0] seg_idx,
    input logic             seg_last,
    input logic [P_W-1:0]   cs_sum,
    input logic [P_W-1:0]   cs_carry,
    input logic             prod_valid,
    input logic [IDX_W-1:0] prod_idx,
    input logic [P_W-1:0]   prod
);

    a_r2_start_raises_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    a_r2_first_slice: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> ##1 (seg_valid && seg_idx == '0));

    a_r4_slice_order: assert property (@(posedge clk) disable iff (rst)
        (seg_valid && !seg_last) |=> (seg_valid && seg_idx == $past(seg_idx) + 1'b1));

    a_r4_last_flag: assert property (@(posedge clk) disable iff (rst)
        seg_valid |-> (seg_last == (seg_idx == IDX_W'(NSEG))));

    a_r4_busy_ends_on_last: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (seg_valid && seg_last));

    a_r5_resolved_follows: assert property (@(posedge clk) disable iff (rst)
        seg_valid |=> (prod_valid && prod_idx == $past(seg_idx)
                       && prod == $past(cs_sum + cs_carry)));

    a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ##1 !(seg_valid && seg_idx == '0));

endmodule

bind booth_seg_mul bsm_chk #(
    .NSEG  (NSEG),
    .IDX_W (IDX_W),
    .P_W   (P_W)
) i_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .seg_valid  (seg_valid),
    .seg_idx    (seg_idx),
    .seg_last   (seg_last),
    .cs_sum     (cs_sum),
    .cs_carry   (cs_carry),
    .prod_valid (prod_valid),
    .prod_idx   (prod_idx),
    .prod       (prod)
);

// File: tb/test_booth_seg_mul.sv
module test_booth_seg_mul;

    localparam int SEG_W = 8;
    localparam int DIG_W = 8;
    localparam int NSEG  = 4;
    localparam int MC_W  = SEG_W * NSEG;
    localparam int P_W   = SEG_W + DIG_W;
    localparam int IDX_W = 3;
    localparam int TW    = (NSEG + 1) * SEG_W;

    logic             clk = 1'b0;
    logic             rst;
    logic             start;
    logic [MC_W-1:0]  mcand;
    logic [DIG_W-1:0] digit;
    logic             busy;
    logic             seg_valid;
    logic [IDX_W-1:0] seg_idx;
    logic             seg_last;
    logic [P_W-1:0]   cs_sum;
    logic [P_W-1:0]   cs_carry;
    logic             prod_valid;
    logic [IDX_W-1:0] prod_idx;
    logic [P_W-1:0]   prod;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    booth_seg_mul #(
        .SEG_W (SEG_W),
        .DIG_W (DIG_W),
        .NSEG  (NSEG)
    ) i_booth_seg_mul (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .mcand      (mcand),
        .digit      (digit),
        .busy       (busy),
        .seg_valid  (seg_valid),
        .seg_idx    (seg_idx),
        .seg_last   (seg_last),
        .cs_sum     (cs_sum),
        .cs_carry   (cs_carry),
        .prod_valid (prod_valid),
        .prod_idx   (prod_idx),
        .prod       (prod)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Slice k times the digit, slice unsigned, digit signed, kept to P_W bits.
    function automatic logic [P_W-1:0] slice_prod(input logic [MC_W-1:0] m,
                                                  input logic [DIG_W-1:0] d, input int k);
        logic [SEG_W-1:0] s;
        longint p;
        s = (k < NSEG) ? m[k*SEG_W +: SEG_W] : {SEG_W{m[MC_W-1]}};
        p = longint'(s) * longint'($signed(d));
        return p[P_W-1:0];
    endfunction

    task automatic run(input logic [MC_W-1:0] m, input logic [DIG_W-1:0] d, input bit poke);
        logic [TW-1:0] acc;
        longint full;
        logic [P_W-1:0] e;
        acc = '0;
        @(negedge clk);
        start = 1'b1; mcand = m; digit = d;
        @(negedge clk);
        start = poke;
        if (poke) begin mcand = ~m; digit = ~d; end
        chk(busy && !seg_valid, "R2 busy after start", {busy, seg_valid}, 2);
        for (int k = 0; k <= NSEG; k++) begin
            @(negedge clk);
            chk(seg_valid && seg_idx == IDX_W'(k) && seg_last == (k == NSEG),
                poke ? "R6 slice index under start" : "R4 slice index",
                {seg_valid, seg_last, seg_idx}, k);
            e = slice_prod(m, d, k);
            chk(P_W'(cs_sum + cs_carry) == e, poke ? "R6 slice value under start" : "R3 slice value",
                P_W'(cs_sum + cs_carry), e);
            if (k > 0) begin
                e = slice_prod(m, d, k - 1);
                chk(prod_valid && prod_idx == IDX_W'(k - 1) && prod == e, "R5 resolved slice",
                    prod, e);
                acc = acc + ({{(TW-P_W){prod[P_W-1]}}, prod} << (SEG_W * (k - 1)));
            end
            if (k == NSEG) begin
                chk(!busy, "R4 busy falls with last slice", busy, 0);
                start = 1'b0;
            end
        end
        @(negedge clk);
        e = slice_prod(m, d, NSEG);
        chk(prod_valid && prod_idx == IDX_W'(NSEG) && prod == e, "R5 resolved last slice", prod, e);
        acc = acc + ({{(TW-P_W){prod[P_W-1]}}, prod} << (SEG_W * NSEG));
        chk(!busy && !seg_valid, "R6 no restart after run", {busy, seg_valid}, 0);
        full = longint'($signed(m)) * longint'($signed(d));
        chk(acc == full[TW-1:0], "R7 weighted sum", acc, full[TW-1:0]);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; mcand = '0; digit = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !seg_valid && !prod_valid, "R1 reset state",
            {busy, seg_valid, prod_valid}, 0);
        rst = 1'b0;

        // Every slice value against every digit; the sign slice takes both polarities.
        for (int d = 0; d < 256; d++) begin
            for (int g = 0; g < 64; g++) begin
                run({8'(4*g + 3), 8'(4*g + 2), 8'(4*g + 1), 8'(4*g)}, 8'(d), (g % 16) == 5);
            end
        end

        // Corner operands: all ones, zero, extreme digits.
        run('1, 8'h80, 1'b0);
        run('0, 8'h7F, 1'b0);
        run('1, '1, 1'b1);
        run(32'h8000_0000, 8'h80, 1'b0);
        run(32'h7FFF_FFFF, 8'h7F, 1'b0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R4 watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule